// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

This block keeps time with a 47-bit counter that advances once per pulse of a slow tick enable. The upper 32 bits of the counter are whole seconds and the lower 15 bits are a binary fraction of a second. Software reaches the block through a 32-bit word-addressed register port. The port covers control, status, the two counter words, an alarm value in seconds and a glitch-detect word. Reads are combinational from the address. A write takes effect on the clock edge where the write strobe is high.

Control bits do not act at once. Each written control value travels through a three-stage pipeline that moves only on ticks. This models the settling time of a slow clock domain. The bits that software reads back are the values currently in effect, so software polls until the bit it wrote appears. The counter accepts a new value only while counting is not in effect.

An alarm compares the seconds field with a programmed value on each tick and latches a status flag, which software clears by writing a one to it. The interrupt output is that flag, gated by the wakeup enable currently in effect.

Top module: `lp_rtc`

## Requirements
- R1: After reset every mapped register reads 0, and `alarm_irq` is 0. An address outside the map (for example 0x08) reads 0.
- R2: Control at 0x04 has bit 0 = count enable, bit 1 = alarm enable and bit 3 = wakeup enable. A written value becomes effective on the third tick after the write, and readback returns the effective bits, with all other bits 0.
- R3: While count enable is effective, each tick adds one to the 47-bit counter. Without an effective count enable, the counter holds.
- R4: Address 0x20 reads counter bits 31:0. Address 0x1C reads counter bits 46:32, zero-extended. Writes to either word load those bits only while count enable is not effective, and are ignored otherwise.
- R5: The seconds value is the counter shifted right by 15. On a tick where alarm enable is effective and the seconds value equals the alarm register, status bit 0 (address 0x18) is set.
- R6: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends up set.
- R7: `alarm_irq` is high exactly when status bit 0 is set and wakeup enable is effective.
- R8: The glitch-detect word at 0x30 stores and returns all 32 written bits, for example 0x41736166.
- R9: The alarm register at 0x24 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow-clock tick enable, one cycle wide |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The alarm compare and the write-one-to-clear of the status flag can act in the same cycle. To provoke this, the bench holds the seconds value equal to the alarm register. It then raises a status write of 1 together with a tick pulse, on the same clock edge. The flag must read 1 after that edge. The bench checks this against a plain write of 1 with no tick, which must read 0.

// File: rtl/lprtc_pkg.sv
package lprtc_pkg;
    localparam int WORD_W = 32;
    localparam logic [7:0] ADDR_CTRL = 8'h04;
    localparam logic [7:0] ADDR_STAT = 8'h18;
    localparam logic [7:0] ADDR_CNTH = 8'h1C;
    localparam logic [7:0] ADDR_CNTL = 8'h20;
    localparam logic [7:0] ADDR_ALRM = 8'h24;
    localparam logic [7:0] ADDR_GLCH = 8'h30;

    typedef struct packed {
        logic wake_en;
        logic alarm_en;
        logic count_en;
    } ctrl_t;
endpackage

// File: rtl/lprtc_ctl_sync.sv
module lprtc_ctl_sync
    import lprtc_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  ctrl_t req,
    output ctrl_t eff
);
    ctrl_t [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (tick) begin
            pipe_d[0] = req;
            for (int i = 1; i < STAGES; i++) begin
                pipe_d[i] = pipe_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign eff = pipe_q[STAGES-1];

    // R2: effective control moves only on a tick
    a_r2_eff_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(eff));
endmodule

// File: rtl/lprtc_counter.sv
module lprtc_counter
    import lprtc_pkg::*;
#(
    parameter int FRAC_W = 15,
    parameter int SEC_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    run,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic [WORD_W-1:0]       wdata,
    output logic [FRAC_W+SEC_W-1:0] cnt
);
    localparam int CNT_W = FRAC_W + SEC_W;
    localparam int HI_W  = CNT_W - WORD_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            if (tick) cnt_d = cnt_q + 1'b1;
        end else begin
            if (wr_lo) cnt_d[WORD_W-1:0]     = wdata;
            if (wr_hi) cnt_d[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R3: one step per tick while running
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R4: no load while running
    a_r4_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && (wr_lo || wr_hi)) |=> $stable(cnt_q));
endmodule

// File: rtl/lprtc_alarm.sv
module lprtc_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic [SEC_W-1:0] secs,
    input  logic [SEC_W-1:0] alarm_val,
    input  logic             clr,
    output logic             flag
);
    logic flag_d, flag_q;
    logic hit;

    always_comb begin
        hit    = tick && arm && (secs == alarm_val);
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (hit) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R6: a set in the same cycle as a clear leaves the flag set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && arm && (secs == alarm_val) && clr) |=> flag_q);
    // R5: flag rises only on a tick with alarm armed
    a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick && arm));
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
    import lprtc_pkg::*;
#(
    parameter int FRAC_W      = 15,
    parameter int SEC_W       = 32,
    parameter int SYNC_STAGES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        alarm_irq
);
    localparam int CNT_W = FRAC_W + SEC_W;
    localparam int HI_W  = CNT_W - WORD_W;

    typedef struct packed {
        ctrl_t             ctrl_req;
        logic [SEC_W-1:0]  alarm;
        logic [WORD_W-1:0] glitch;
    } regs_t;

    regs_t            r_d, r_q;
    ctrl_t            eff;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             wr_ctrl, wr_stat, wr_lo, wr_hi, wr_alrm, wr_glch;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);
        wr_lo   = reg_wr && (reg_addr == ADDR_CNTL);
        wr_hi   = reg_wr && (reg_addr == ADDR_CNTH);
        wr_alrm = reg_wr && (reg_addr == ADDR_ALRM);
        wr_glch = reg_wr && (reg_addr == ADDR_GLCH);

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl_req.count_en = reg_wdata[0];
            r_d.ctrl_req.alarm_en = reg_wdata[1];
            r_d.ctrl_req.wake_en  = reg_wdata[3];
        end
        if (wr_alrm) r_d.alarm  = reg_wdata[SEC_W-1:0];
        if (wr_glch) r_d.glitch = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    lprtc_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .req   (r_q.ctrl_req),
        .eff   (eff)
    );

    lprtc_counter #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (eff.count_en),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .cnt   (cnt)
    );

    lprtc_alarm #(.SEC_W(SEC_W)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .arm       (eff.alarm_en),
        .secs      (cnt[CNT_W-1:FRAC_W]),
        .alarm_val (r_q.alarm),
        .clr       (wr_stat && reg_wdata[0]),
        .flag      (flag)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {28'd0, eff.wake_en, 1'b0, eff.alarm_en, eff.count_en};
            ADDR_STAT: reg_rdata = {31'd0, flag};
            ADDR_CNTH: reg_rdata = {{(WORD_W-HI_W){1'b0}}, cnt[CNT_W-1:WORD_W]};
            ADDR_CNTL: reg_rdata = cnt[WORD_W-1:0];
            ADDR_ALRM: reg_rdata = r_q.alarm;
            ADDR_GLCH: reg_rdata = r_q.glitch;
            default:   reg_rdata = '0;
        endcase
    end

    assign alarm_irq = flag && eff.wake_en;

    // R7: interrupt never without a latched flag
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> flag);
    // R9: alarm value changes only through a write to its address
    a_r9_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_alrm |=> $stable(r_q.alarm));
endmodule

// File: tb/sim_lp_rtc.sv
module sim_lp_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        alarm_irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] m;

    always #4 clk = ~clk;

    lp_rtc u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic chk_counter(input string req);
        rd_chk(req, 8'h20, m[31:0]);
        rd_chk(req, 8'h1C, {17'd0, m[46:32]});
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h04, 0);
        rd_chk("R1 status", 8'h18, 0);
        rd_chk("R1 cnt hi", 8'h1C, 0);
        rd_chk("R1 cnt lo", 8'h20, 0);
        rd_chk("R1 alarm", 8'h24, 0);
        rd_chk("R1 glitch", 8'h30, 0);
        rd_chk("R1 unmapped", 8'h08, 0);
        chk("R1 irq", {31'd0, alarm_irq}, 0);
    endtask

    task automatic t_regs;
        wr(8'h30, 32'h41736166);
        rd_chk("R8 glitch", 8'h30, 32'h41736166);
        wr(8'h24, 32'hDEADBEEF);
        rd_chk("R9 alarm", 8'h24, 32'hDEADBEEF);
    endtask

    task automatic t_load_and_run;
        m = ({32'd0, 32'hABCD1234} << 15) | 64'h7FF0;
        wr(8'h20, m[31:0]);
        wr(8'h1C, m[63:32]);
        chk_counter("R4 load");
        chk("R5 seconds", 32'(m >> 15), 32'hABCD1234);
        wr(8'h04, 32'h1);
        ticks(2);
        rd_chk("R2 ctrl not yet", 8'h04, 0);
        ticks(1);
        rd_chk("R2 ctrl effective", 8'h04, 1);
        chk_counter("R3 no count during delay");
        ticks(5);
        m = m + 5;
        chk_counter("R3 five ticks");
        wr(8'h20, 32'h12345678);
        wr(8'h1C, 32'h7);
        chk_counter("R4 write ignored while counting");
        ticks(11);
        m = m + 11;
        chk_counter("R3 carry into seconds");
        wr(8'h04, 32'h0);
        ticks(3);
        m = m + 3;
        rd_chk("R2 ctrl off", 8'h04, 0);
        ticks(2);
        chk_counter("R3 hold when disabled");
    endtask

    task automatic t_alarm;
        logic [31:0] secs;
        secs = 32'h00001000;
        m = ({32'd0, secs} << 15) | 64'h7FFA;
        wr(8'h20, m[31:0]);
        wr(8'h1C, m[63:32]);
        wr(8'h24, secs + 1);
        wr(8'h04, 32'hB);
        ticks(3);
        rd_chk("R2 ctrl all bits", 8'h04, 32'hB);
        rd_chk("R5 no early flag", 8'h18, 0);
        ticks(6);
        rd_chk("R5 no flag before match", 8'h18, 0);
        chk("R7 irq low", {31'd0, alarm_irq}, 0);
        ticks(1);
        rd_chk("R5 flag on match", 8'h18, 1);
        chk("R7 irq high", {31'd0, alarm_irq}, 1);
        wr(8'h04, 32'h3);
        ticks(3);
        rd_chk("R7 flag kept", 8'h18, 1);
        chk("R7 irq gated", {31'd0, alarm_irq}, 0);
        wr(8'h18, 32'h0);
        rd_chk("R6 write zero no effect", 8'h18, 1);
        wr(8'h18, 32'h1);
        rd_chk("R6 clear", 8'h18, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h1; tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick = 1'b0;
        rd_chk("R6 set wins over clear", 8'h18, 1);
        wr(8'h04, 32'h1);
        ticks(3);
        wr(8'h18, 32'hFFFFFFFF);
        ticks(2);
        rd_chk("R5 disarmed stays clear", 8'h18, 0);
    endtask

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_load_and_run;
        t_alarm;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule